// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block lives in the execute stage of a five-stage, 64-bit load/store pipeline. For each of the two ALU operands it decides where the value should come from. There are three possible sources. The first is the register-file value that was read during decode. The second is the ALU result of the instruction one stage ahead, in the memory stage. The third is the value about to be written back, which is either loaded data or an older ALU result.

The block compares each operand's source register number with the destination register numbers of the two later stages. It also checks their register-write enables. From these it produces a 2-bit select code per operand and drives the selected 64-bit value. When both later stages would supply the same operand, the younger instruction (the one in the memory stage) wins. Register 31 is the hardwired zero register, so it never serves as a bypass source.

The block is purely combinational and holds no state. The ALU, the pipeline registers and load-use stall handling belong to other blocks.

Top module: `fwd_unit`

## Requirements
- R1: When neither later stage matches an operand's source register, that operand's select code is 2'b00 and the operand equals its register-file value.
- R2: When the memory-stage write enable is 1, its destination is not 31 and its destination equals the operand's source register, the select code is 2'b10 and the operand equals the memory-stage ALU result.
- R3: When the write-back write enable is 1, its destination is not 31, it equals the operand's source register and R2 does not apply to that operand, the select code is 2'b01 and the operand equals the write-back value.
- R4: When both later stages match the same operand, the memory-stage result is chosen (select code 2'b10).
- R5: A destination of 31 never causes a bypass, whatever the write enables; an operand whose source register is 31 always gets select code 2'b00.
- R6: A stage whose write enable is 0 never supplies a bypass, even when its destination matches.
- R7: The first operand is matched against the first source field and the second against the second source field, and the two select codes are independent.
- R8: The select code 2'b11 is never produced on either operand.
- R9: Outputs follow input changes without any clock edge.
- R10: After three back-to-back writes to one register, an instruction that reads it receives the most recent value. This holds with no gap, and also when a bubble moves the latest write into the write-back stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a_reg | input | 5 | First operand source register number (decode/execute register) |
| src_b_reg | input | 5 | Second operand source register number (decode/execute register) |
| mem_dst_reg | input | 5 | Destination register of the instruction in the memory stage |
| mem_wr_en | input | 1 | Register-write enable of the memory-stage instruction |
| wb_dst_reg | input | 5 | Destination register of the instruction in the write-back stage |
| wb_wr_en | input | 1 | Register-write enable of the write-back instruction |
| rf_a_val | input | 64 | Register-file value read for the first operand |
| rf_b_val | input | 64 | Register-file value read for the second operand |
| mem_alu_val | input | 64 | ALU result held in the memory stage |
| wb_val | input | 64 | Value about to be written back |
| sel_a | output | 2 | First operand source: 00 register file, 10 memory stage, 01 write-back |
| sel_b | output | 2 | Second operand source, same encoding |
| opnd_a | output | 64 | Selected first operand |
| opnd_b | output | 64 | Selected second operand |

## Verification
The case hardest to reach from the ports is a match that is real but must be refused. Examples are a destination of 31 with its write enable set, or a write-back match hidden behind a memory-stage match on the same operand. Each of these needs several fields to line up at once. The vector table builds them directly, including rows where one stage matches operand A and the other stage matches operand B. The three-write chain is replayed by a bench-side model of the pipeline that shifts its own write records each clock, so the priority rule is exercised in the order a real program produces it.

// File: rtl/fwd_pkg.sv
// Shared definitions for the operand bypass selector.
// Assumes a fixed 2-bit select encoding consumed by the operand muxes.
package fwd_pkg;

    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_WB  = 2'b01,
        SRC_MEM = 2'b10
    } fwd_src_e;

endpackage

// File: rtl/fwd_detect.sv
// Hazard detection for one operand: compares the operand's source
// register against the two later stages and picks the youngest valid
// producer. Assumes ZERO_REG names a register that is never written.
module fwd_detect
    import fwd_pkg::*;
#(
    parameter int REG_AW   = 5,
    parameter int ZERO_REG = 31
) (
    input  logic [REG_AW-1:0] src_reg,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic              mem_wen,
    input  logic [REG_AW-1:0] wb_dst,
    input  logic              wb_wen,
    output fwd_src_e          sel
);

    localparam logic [REG_AW-1:0] ZREG = REG_AW'(ZERO_REG);

    logic mem_hit;
    logic wb_hit;

    // Qualify each stage: write enabled, not the zero register, same number.
    always_comb begin
        mem_hit = mem_wen && (mem_dst != ZREG) && (mem_dst == src_reg);
        wb_hit  = wb_wen  && (wb_dst  != ZREG) && (wb_dst  == src_reg);
    end

    // Priority: the younger memory-stage producer shadows write-back.
    always_comb begin
        if (mem_hit)
            sel = SRC_MEM;
        else if (wb_hit)
            sel = SRC_WB;
        else
            sel = SRC_RF;
    end

    // A source of the zero register can never match a legal producer.
    always_comb begin
        AST_ZERO_NEVER_BYPASSED: assert (!(src_reg == ZREG) || sel == SRC_RF) // R5
            else $error("zero register selected a bypass");
        AST_DISABLED_WB_IGNORED: assert (wb_wen || sel != SRC_WB) // R6
            else $error("write-back bypass without write enable");
    end

endmodule

// File: rtl/fwd_mux.sv
// Operand multiplexer for one ALU input. Assumes the select follows the
// package encoding; the unused code 11 falls back to the register file.
module fwd_mux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] mem_val,
    input  logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] opnd
);

    // Route the chosen source; any other code behaves as register file.
    always_comb begin
        case (sel)
            SRC_MEM: opnd = mem_val;
            SRC_WB:  opnd = wb_val;
            default: opnd = rf_val;
        endcase
    end

endmodule

// File: rtl/fwd_unit.sv
// Execute-stage operand bypass selector. One detector and one mux per
// ALU operand, built by a generate loop. Purely combinational; assumes
// the pipeline registers feeding it are held elsewhere.
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int REG_AW   = 5,
    parameter int ZERO_REG = 31
) (
    input  logic [REG_AW-1:0] src_a_reg,
    input  logic [REG_AW-1:0] src_b_reg,
    input  logic [REG_AW-1:0] mem_dst_reg,
    input  logic              mem_wr_en,
    input  logic [REG_AW-1:0] wb_dst_reg,
    input  logic              wb_wr_en,
    input  logic [DATA_W-1:0] rf_a_val,
    input  logic [DATA_W-1:0] rf_b_val,
    input  logic [DATA_W-1:0] mem_alu_val,
    input  logic [DATA_W-1:0] wb_val,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);

    localparam int NUM_OPND = 2;

    logic [REG_AW-1:0] src_arr [NUM_OPND];
    logic [DATA_W-1:0] rf_arr  [NUM_OPND];
    logic [1:0]        sel_arr [NUM_OPND];
    logic [DATA_W-1:0] out_arr [NUM_OPND];

    // Gather the per-operand inputs into indexed arrays.
    always_comb begin
        src_arr[0] = src_a_reg;
        src_arr[1] = src_b_reg;
        rf_arr[0]  = rf_a_val;
        rf_arr[1]  = rf_b_val;
    end

    for (genvar i = 0; i < NUM_OPND; i++) begin : g_opnd
        fwd_src_e det_sel;

        fwd_detect #(
            .REG_AW   (REG_AW),
            .ZERO_REG (ZERO_REG)
        ) u_det (
            .src_reg (src_arr[i]),
            .mem_dst (mem_dst_reg),
            .mem_wen (mem_wr_en),
            .wb_dst  (wb_dst_reg),
            .wb_wen  (wb_wr_en),
            .sel     (det_sel)
        );

        assign sel_arr[i] = det_sel;

        fwd_mux #(
            .DATA_W (DATA_W)
        ) u_mux (
            .sel     (sel_arr[i]),
            .rf_val  (rf_arr[i]),
            .mem_val (mem_alu_val),
            .wb_val  (wb_val),
            .opnd    (out_arr[i])
        );

        // Cross-check detector output against the mux data path.
        always_comb begin
            AST_SEL_LEGAL: assert (sel_arr[i] != 2'b11) // R8
                else $error("illegal select code");
            AST_MEM_DATA_ROUTED: assert (sel_arr[i] != 2'b10 || out_arr[i] == mem_alu_val) // R2
                else $error("memory-stage value not routed");
            AST_WB_DATA_ROUTED: assert (sel_arr[i] != 2'b01 || out_arr[i] == wb_val) // R3
                else $error("write-back value not routed");
            AST_YOUNGER_WINS: assert (!(mem_wr_en && mem_dst_reg == src_arr[i]
                                        && mem_dst_reg != REG_AW'(ZERO_REG))
                                      || sel_arr[i] == 2'b10) // R4
                else $error("younger producer not chosen");
        end
    end

    // Drive the named output ports from the operand arrays.
    always_comb begin
        sel_a  = sel_arr[0];
        sel_b  = sel_arr[1];
        opnd_a = out_arr[0];
        opnd_b = out_arr[1];
    end

endmodule

// File: tb/fwd_unit_test.sv
module fwd_unit_test;

    localparam int DW = 64;
    localparam logic [DW-1:0] RF_A = 64'h0A0A_0000_0000_1111;
    localparam logic [DW-1:0] RF_B = 64'h0B0B_0000_0000_2222;
    localparam logic [DW-1:0] MEMV = 64'hC0DE_0000_0000_3333;
    localparam logic [DW-1:0] WBV  = 64'hFEED_0000_0000_4444;

    typedef struct packed {
        logic [4:0] ra;
        logic [4:0] rb;
        logic [4:0] md;
        logic       mw;
        logic [4:0] wd;
        logic       ww;
        logic [1:0] ea;
        logic [1:0] eb;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{5'd1,  5'd2,  5'd3,  1'b1, 5'd4,  1'b1, 2'b00, 2'b00}, // R1 no match
        '{5'd1,  5'd2,  5'd1,  1'b1, 5'd4,  1'b1, 2'b10, 2'b00}, // R2 memory stage
        '{5'd5,  5'd6,  5'd7,  1'b1, 5'd6,  1'b1, 2'b00, 2'b01}, // R3 write-back
        '{5'd8,  5'd8,  5'd8,  1'b1, 5'd8,  1'b1, 2'b10, 2'b10}, // R4 both match
        '{5'd9,  5'd10, 5'd9,  1'b0, 5'd9,  1'b1, 2'b01, 2'b00}, // R6 mem disabled
        '{5'd31, 5'd31, 5'd31, 1'b1, 5'd31, 1'b1, 2'b00, 2'b00}, // R5 zero reg
        '{5'd12, 5'd13, 5'd31, 1'b1, 5'd13, 1'b1, 2'b00, 2'b01}, // R5 mem dest 31
        '{5'd14, 5'd15, 5'd15, 1'b1, 5'd14, 1'b1, 2'b01, 2'b10}, // R7 split sources
        '{5'd0,  5'd0,  5'd0,  1'b1, 5'd3,  1'b0, 2'b10, 2'b10}, // R2 register 0 ok
        '{5'd20, 5'd21, 5'd20, 1'b0, 5'd21, 1'b0, 2'b00, 2'b00}  // R6 both disabled
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [4:0]    src_a_reg, src_b_reg, mem_dst_reg, wb_dst_reg;
    logic          mem_wr_en, wb_wr_en;
    logic [DW-1:0] rf_a_val, rf_b_val, mem_alu_val, wb_val;
    logic [1:0]    sel_a, sel_b;
    logic [DW-1:0] opnd_a, opnd_b;

    int total = 0;
    int bad = 0;

    fwd_unit uut (
        .src_a_reg   (src_a_reg),
        .src_b_reg   (src_b_reg),
        .mem_dst_reg (mem_dst_reg),
        .mem_wr_en   (mem_wr_en),
        .wb_dst_reg  (wb_dst_reg),
        .wb_wr_en    (wb_wr_en),
        .rf_a_val    (rf_a_val),
        .rf_b_val    (rf_b_val),
        .mem_alu_val (mem_alu_val),
        .wb_val      (wb_val),
        .sel_a       (sel_a),
        .sel_b       (sel_b),
        .opnd_a      (opnd_a),
        .opnd_b      (opnd_b)
    );

    function automatic logic [DW-1:0] pick(input logic [1:0] s, input logic [DW-1:0] rf);
        case (s)
            2'b10:   return mem_alu_val;
            2'b01:   return wb_val;
            default: return rf;
        endcase
    endfunction

    task automatic check(input string req, input logic [1:0] ea, input logic [1:0] eb);
        logic [DW-1:0] xa;
        logic [DW-1:0] xb;
        xa = pick(ea, rf_a_val);
        xb = pick(eb, rf_b_val);
        total++;
        if (sel_a !== ea || sel_b !== eb || opnd_a !== xa || opnd_b !== xb) begin
            bad++;
            $display("FAIL %s: sel_a=%b sel_b=%b opnd_a=%h opnd_b=%h expected %b %b %h %h",
                     req, sel_a, sel_b, opnd_a, opnd_b, ea, eb, xa, xb);
        end
        if (sel_a === 2'b11 || sel_b === 2'b11) begin
            bad++;
            $display("FAIL R8: select 11 seen, got %b %b expected no 11", sel_a, sel_b);
        end
    endtask

    task automatic drive(input logic [4:0] ra, input logic [4:0] rb, input logic [4:0] md,
                         input logic mw, input logic [4:0] wd, input logic ww);
        src_a_reg   = ra;
        src_b_reg   = rb;
        mem_dst_reg = md;
        mem_wr_en   = mw;
        wb_dst_reg  = wd;
        wb_wr_en    = ww;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #(8 * 5000);
        bad++;
        total++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] mem_rec_val;
        logic [DW-1:0] wb_rec_val;
        logic          mem_rec_w;
        logic          wb_rec_w;

        rf_a_val    = RF_A;
        rf_b_val    = RF_B;
        mem_alu_val = MEMV;
        wb_val      = WBV;
        drive(5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0);
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle", 2'b00, 2'b00);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].ra, VECS[i].rb, VECS[i].md, VECS[i].mw, VECS[i].wd, VECS[i].ww);
            @(negedge clk);
            check($sformatf("vector %0d", i), VECS[i].ea, VECS[i].eb);
        end

        // R9: change inputs between edges, result visible without a clock edge
        @(posedge clk);
        #1;
        drive(5'd3, 5'd4, 5'd3, 1'b1, 5'd4, 1'b1);
        #1;
        check("R9 no-edge update", 2'b10, 2'b01);
        mem_dst_reg = 5'd9;
        #1;
        check("R9 no-edge update 2", 2'b00, 2'b01);

        // R10: three writes to register 1, bench-side pipeline shift model
        mem_rec_val = '0;
        wb_rec_val  = '0;
        mem_rec_w   = 1'b0;
        wb_rec_w    = 1'b0;
        for (int k = 1; k <= 3; k++) begin
            @(posedge clk);
            wb_rec_val  = mem_rec_val;
            wb_rec_w    = mem_rec_w;
            mem_rec_val = 64'h1000 + 64'(k);
            mem_rec_w   = 1'b1;
        end
        @(negedge clk);
        mem_alu_val = mem_rec_val;
        wb_val      = wb_rec_val;
        drive(5'd1, 5'd1, 5'd1, mem_rec_w, 5'd1, wb_rec_w);
        #1;
        check("R10 chain newest", 2'b10, 2'b10);
        if (opnd_a !== 64'h1003) begin
            bad++;
            $display("FAIL R10: opnd_a=%h expected %h", opnd_a, 64'h1003);
        end
        total++;
        // A bubble: newest write moves to write-back, memory stage idle
        @(posedge clk);
        wb_rec_val  = mem_rec_val;
        wb_rec_w    = mem_rec_w;
        mem_rec_val = 64'h0;
        mem_rec_w   = 1'b0;
        @(negedge clk);
        mem_alu_val = mem_rec_val;
        wb_val      = wb_rec_val;
        drive(5'd1, 5'd2, 5'd1, mem_rec_w, 5'd1, wb_rec_w);
        #1;
        check("R10 chain after bubble", 2'b01, 2'b00);
        if (opnd_a !== 64'h1003) begin
            bad++;
            $display("FAIL R10: opnd_a=%h expected %h", opnd_a, 64'h1003);
        end
        total++;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule